// File: doc/BRIEF.md
# Symmetric Saturating Sigmoid Evaluator

This block takes a 12-bit signed fixed-point sample and returns the logistic sigmoid of it. The input has 8 fractional bits and 4 integer bits, with the sign in bit 11. The output uses the same format. It is never negative and never larger than 1.0.

Only the right half of the curve is stored, from 0 up to a saturation threshold of 6.234375. It is held as two small tables. A base table keeps the smallest value of each band of eight neighbouring samples. A narrow offset table keeps, for every sample, how far it sits above its band's base. The stored value is base plus offset, with only the 8 fractional bits kept.

The evaluator works on the magnitude of the input. Magnitudes past the threshold skip the tables and give exactly 1.0. A negative input has its positive-side result reflected as 1.0 minus that result. The block is a two-stage pipeline with a valid flag at each end, and it accepts a new sample every cycle.

Top module: `sig_eval_top`

## Requirements
- R1: For an input code from 0 to 1596, the output is round(256 / (1 + e^(-code/256))) with halves rounded up, capped at 255.
- R2: For a negative input whose magnitude is 1596 or less, the output is 256 minus the value R1 gives for that magnitude.
- R3: A non-negative input above code 1596 gives output code 256 (1.0).
- R4: A negative input whose magnitude lies from 1597 to 2047 gives output code 0.
- R5: The input code 0x800 (-8.0) has no positive counterpart and gives output code 0.
- R6: The threshold is inclusive. Magnitude 1596 is read from the tables, and magnitude 1597 saturates.
- R7: A sample presented with inValid high at a rising edge appears with outValid high exactly two rising edges later. outValid is low two edges after any cycle with inValid low, and samples may arrive on every cycle.
- R8: While rstN is low, outValid is low.
- R9: Whenever outValid is high, outData lies between 0 and 256 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks inData as a sample to evaluate |
| inData | input | 12 | Signed input, 4 integer bits (sign included) and 8 fractional bits |
| outValid | output | 1 | Marks outData as a result |
| outData | output | 12 | Sigmoid result in the same format, 0 to 256 |

## Verification
The port-level properties assume that inValid and inData are driven to known values on every clock after reset. They also assume that inValid is low while reset is asserted, so that the two-edge window starts clean. The stimulus changes inputs only on the falling edge and holds inValid low through reset. It then sweeps every one of the 4096 codes back to back, including the edge codes 1596, 1597, -1596, -1597 and 0x800. Bubble patterns probe the valid alignment, and a flush after each run drains the pipeline.

// File: rtl/sig_pkg.sv
package sig_pkg;

  parameter int IN_W      = 12;
  parameter int FRAC_W    = 8;
  parameter int HI_CODE   = 1596;
  parameter int BAND_LOG2 = 3;
  parameter int ERR_W     = 2;

  localparam int BAND      = 1 << BAND_LOG2;
  localparam int DEPTH     = HI_CODE + 1;
  localparam int NUM_BANDS = (DEPTH + BAND - 1) / BAND;
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int BAND_AW   = ADDR_W - BAND_LOG2;
  localparam int ONE_CODE  = 1 << FRAC_W;
  localparam int MAX_FRAC  = ONE_CODE - 1;

  typedef struct packed {
    logic loadS1;   // capture the magnitude address
    logic readTbl;  // enable both tables this cycle
    logic negOut;   // reflect the result through 1.0
    logic satOut;   // replace the table value by 1.0
    logic valid;    // result on the output is live
  } sig_strobe_t;

  // Quantised positive-half sample used to fill the tables.
  function automatic int sigCode(input int n);
    real x;
    real s;
    int  r;
    x = real'(n) / real'(ONE_CODE);
    s = 1.0 / (1.0 + $exp(-x));
    r = int'($floor(s * real'(ONE_CODE) + 0.5));
    if (r > MAX_FRAC) r = MAX_FRAC;
    return r;
  endfunction

endpackage

// File: rtl/sig_ctrl.sv
module sig_ctrl
  import sig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSign,
  input  logic        inSat,
  output sig_strobe_t strb
);

  logic vS1, negS1, satS1;
  logic vS2, negS2, satS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vS1   <= 1'b0;
      negS1 <= 1'b0;
      satS1 <= 1'b0;
      vS2   <= 1'b0;
      negS2 <= 1'b0;
      satS2 <= 1'b0;
    end else begin
      vS1   <= inValid;
      negS1 <= inValid & inSign;
      satS1 <= inValid & inSat;
      vS2   <= vS1;
      negS2 <= negS1;
      satS2 <= satS1;
    end
  end

  always_comb begin
    strb.loadS1  = inValid;
    strb.readTbl = vS1 & ~satS1;
    strb.negOut  = negS2;
    strb.satOut  = satS2;
    strb.valid   = vS2;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |-> !vS2) else $error("outValid high in reset"); // R8

endmodule

// File: rtl/sig_datapath.sv
module sig_datapath
  import sig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   inData,
  input  sig_strobe_t       strb,
  output logic              inSat,
  output logic [IN_W-1:0]   outData
);

  logic [IN_W-1:0]   inMag;
  logic [ADDR_W-1:0] s1Addr;
  logic [FRAC_W-1:0] baseMem [NUM_BANDS];
  logic [ERR_W-1:0]  errMem  [DEPTH];
  logic [FRAC_W-1:0] baseQ;
  logic [ERR_W-1:0]  errQ;
  logic [IN_W-1:0]   posVal;

  // Magnitude: 0x800 maps to 2048, which lies past the threshold.
  assign inMag = inData[IN_W-1] ? (~inData + 1'b1) : inData;
  assign inSat = (inMag > IN_W'(HI_CODE));

  always_ff @(posedge clk) begin
    if (strb.loadS1) s1Addr <= inMag[ADDR_W-1:0];
  end

  // Band-compressed contents: minimum per band, offset per sample.
  initial begin
    for (int b = 0; b < NUM_BANDS; b++) begin
      int lo;
      lo = MAX_FRAC;
      for (int k = 0; k < BAND; k++) begin
        int idx;
        idx = b * BAND + k;
        if (idx < DEPTH && sigCode(idx) < lo) lo = sigCode(idx);
      end
      baseMem[b] = FRAC_W'(lo);
      for (int k = 0; k < BAND; k++) begin
        int idx;
        idx = b * BAND + k;
        if (idx < DEPTH) begin
          AST_OFFSET_FITS: assert (sigCode(idx) - lo < (1 << ERR_W)) else $error("offset overflow at %0d", idx); // R1
          errMem[idx] = ERR_W'(sigCode(idx) - lo);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.readTbl) begin
      baseQ <= baseMem[s1Addr[ADDR_W-1:BAND_LOG2]];
      errQ  <= errMem[s1Addr];
    end
  end

  always_comb begin
    posVal  = strb.satOut ? IN_W'(ONE_CODE) : (IN_W'(baseQ) + IN_W'(errQ));
    outData = strb.negOut ? (IN_W'(ONE_CODE) - posVal) : posVal;
  end

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rstN) strb.valid |-> outData <= IN_W'(ONE_CODE)) else $error("output out of range"); // R9

endmodule

// File: rtl/sig_eval_top.sv
module sig_eval_top
  import sig_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [IN_W-1:0] inData,
  output logic            outValid,
  output logic [IN_W-1:0] outData
);

  sig_strobe_t strb;
  logic        inSat;

  sig_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSign  (inData[IN_W-1]),
    .inSat   (inSat),
    .strb    (strb)
  );

  sig_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strb    (strb),
    .inSat   (inSat),
    .outData (outData)
  );

  assign outValid = strb.valid;

  AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rstN) inValid |=> ##1 outValid) else $error("valid lost"); // R7
  AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> ##1 !outValid) else $error("spurious valid"); // R7
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN) (inValid && !inData[IN_W-1] && inData > IN_W'(HI_CODE)) |=> ##1 (outData == IN_W'(ONE_CODE))) else $error("no high saturation"); // R3
  AST_MIN_CODE: assert property (@(posedge clk) disable iff (!rstN) (inValid && inData == {1'b1, {(IN_W-1){1'b0}}}) |=> ##1 (outData == '0)) else $error("most negative code not zero"); // R5
  AST_POS_HALF: assert property (@(posedge clk) disable iff (!rstN) (inValid && !inData[IN_W-1]) |=> ##1 (outData >= IN_W'(ONE_CODE / 2))) else $error("positive below half"); // R1
  AST_NEG_HALF: assert property (@(posedge clk) disable iff (!rstN) (inValid && inData[IN_W-1]) |=> ##1 (outData <= IN_W'(ONE_CODE / 2))) else $error("negative above half"); // R2

endmodule

// File: tb/sig_eval_top_tb.sv
`timescale 1ns/1ps
module sig_eval_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inData = '0;
  logic        outValid;
  logic [11:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic        d1v = 1'b0, d2v = 1'b0;
  logic [11:0] d1c = '0,   d2c = '0;

  always #2.5 clk = ~clk;

  sig_eval_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

  function automatic int refPos(input int m);
    real s;
    int  r;
    if (m > 1596) return 256;
    s = 1.0 / (1.0 + $exp(-real'(m) / 256.0));
    r = int'($floor(s * 256.0 + 0.5));
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic int magOf(input logic [11:0] c);
    return c[11] ? (4096 - int'(c)) : int'(c);
  endfunction

  function automatic int refOut(input logic [11:0] c);
    int p;
    p = refPos(magOf(c));
    return c[11] ? 256 - p : p;
  endfunction

  function automatic string tagOf(input logic [11:0] c);
    int m;
    m = magOf(c);
    if (c == 12'h800)            return "R5";
    if (m == 1596 || m == 1597)  return "R6";
    if (m > 1596)                return c[11] ? "R4" : "R3";
    return c[11] ? "R2" : "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: compare the sample issued two falling edges ago, then drive.
  task automatic step(input logic v, input logic [11:0] c);
    @(negedge clk);
    if (outValid !== d2v)
      check(1'b0, "R7", int'(outValid), int'(d2v));
    else if (d2v)
      check(int'(outData) == refOut(d2c), tagOf(d2c), int'(outData), refOut(d2c));
    else
      check(1'b1, "R7", 0, 0);
    d2v = d1v; d2c = d1c;
    d1v = v;   d1c = c;
    inValid = v; inData = c;
  endtask

  task automatic flush();
    step(1'b0, '0);
    step(1'b0, '0);
    step(1'b0, '0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8", int'(outValid), 0);
    rstN = 1'b1;
    flush();
  endtask

  task automatic testBoundaries();
    step(1'b1, 12'd1596);   // R6 table edge
    step(1'b1, 12'd1597);   // R6 saturates
    step(1'b1, 12'd0);      // R1 centre
    step(1'b1, -12'sd1596); // R6 negative edge
    step(1'b1, -12'sd1597); // R4
    step(1'b1, 12'h800);    // R5
    step(1'b1, 12'd2047);   // R3
    step(1'b1, 12'hFFF);    // R2 smallest negative
    flush();
  endtask

  task automatic testSweep();
    for (int i = 0; i < 4096; i++) step(1'b1, 12'(i));
    flush();
  endtask

  task automatic testBubbles();
    for (int i = 0; i < 60; i++) step((i % 3) == 0, 12'(i * 97));
    for (int i = 0; i < 20; i++) step((i % 2) == 1, 12'(4095 - i * 131));
    flush();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testBoundaries();
    testSweep();
    testBubbles();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule